// File: doc/BRIEF.md
# Two-Bank Static RAM Control Decode

This block is the memory-side control logic of a byte-wide static RAM built from two banks of equal size. It takes active-low chip-select, output-enable and write-enable strobes and turns them into four operating modes: deselected, output disabled, read and write. It also drives the tri-state data bus as a split pair of data-out and output-enable signals. The top address bit picks one of the two banks and drives a separate enable for each bank. A small storage array of parameterized depth sits behind the decode, so the read and write paths can be checked end to end.

The strobes are sampled on a clock. A write window opens at the first edge where both chip-select and write-enable are seen low. It closes at the first edge where either one is seen high. The byte on the bus at the closing edge is stored at the address captured when the window opened. Two inputs block all access: a write-protect input and a power-fail input. While either is high, the block acts as deselected. An address change inside an open window raises an error flag.

Top module: `sram_bank_ctrl`

## Requirements
- R1: While `ce_ni` is high, `dq_oe_o` is 0 and both bits of `bank_ce_o` are 0.
- R2: With `ce_ni` low, `oe_ni` high and `we_ni` high (output disabled), `dq_oe_o` is 0.
- R3: With `ce_ni` low, `oe_ni` low and `we_ni` high (read), `dq_oe_o` is 1 and `dq_o` shows the byte stored at `addr_i`.
- R4: With `ce_ni` and `we_ni` both low, `dq_oe_o` is 0 whatever `oe_ni` is, and `wr_open_o` is 1 after the next clock edge.
- R5: The window opens at the first clock edge that sees both `ce_ni` and `we_ni` low. It closes at the first edge that sees either one high. The byte stored is `dq_i` as sampled at that closing edge, even if `dq_i` changed while the window was open.
- R6: The byte is stored at the address sampled on `addr_i` at the opening edge.
- R7: During a read, `we_ni` going low drops `dq_oe_o` to 0 in the same cycle.
- R8: Suppose the window opens at the first edge where chip-select is seen active (chip-select fell together with or after write-enable). Then `dq_oe_o` stays 0 until an edge sees `ce_ni` high again, even if `we_ni` rises with `oe_ni` low.
- R9: Suppose chip-select was already active before the window opened. Then `dq_oe_o` returns to 1 in the cycle where `we_ni` is seen high while `ce_ni` and `oe_ni` stay low. From the cycle after, `dq_o` shows the new byte.
- R10: While selected, only bit `addr_i[ADDR_W-1]` of `bank_ce_o` is 1 (bit 0 for the lower half of the address range, bit 1 for the upper half).
- R11: While `wp_i` or `pfail_i` is high, the block behaves as deselected. `dq_oe_o` is 0 and `bank_ce_o` is 0, no window opens, and an open window closes without storing anything.
- R12: An edge that sees `addr_i` differ from the captured address, while the window is open and still active, sets `addr_err_o`. It stays set until the next window opens or reset.
- R13: After reset, `wr_open_o`, `addr_err_o` and `dq_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| wp_i | input | 1 | Write protect; forces the deselected behaviour |
| pfail_i | input | 1 | Power-fail indication; forces the deselected behaviour |
| addr_i | input | ADDR_W | Byte address; the top bit selects the bank |
| dq_i | input | DATA_W | Data arriving from the bus |
| dq_o | output | DATA_W | Data driven onto the bus |
| dq_oe_o | output | 1 | Bus driver enable |
| bank_ce_o | output | 2 | Per-bank enables, active high |
| wr_open_o | output | 1 | Write window currently open |
| addr_err_o | output | 1 | Address changed inside an open write window |

## Verification
The assertions assume the strobes and the address are synchronous to `clk_i`. They also assume every input change is seen by at least one clock edge, so that a fall and a rise of a strobe never both land between two edges. The stimulus changes inputs just after a rising edge and holds each setting for at least a full cycle. It breaks the rule on address stability inside a write window on purpose exactly once, to exercise the error flag. Outputs are sampled at the falling edge, after the previous edge's register updates have settled.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [1:0] {
    MODE_DESEL,
    MODE_ODIS,
    MODE_READ,
    MODE_WRITE
  } sbc_mode_e;
endpackage

// File: rtl/sbc_decode.sv
module sbc_decode
  import sbc_pkg::*;
(
  input  logic      ce_ni,
  input  logic      oe_ni,
  input  logic      we_ni,
  input  logic      block_i,
  output sbc_mode_e mode_o,
  output logic      sel_o
);
  always_comb begin
    sel_o = ~ce_ni & ~block_i;
    if (!sel_o)      mode_o = MODE_DESEL;
    else if (!we_ni) mode_o = MODE_WRITE;   // oe_ni ignored
    else if (!oe_ni) mode_o = MODE_READ;
    else             mode_o = MODE_ODIS;
  end
endmodule

// File: rtl/sbc_wr_track.sv
module sbc_wr_track #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_ni,
  input  logic              block_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              open_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              suppress_o,
  output logic              err_o
);
  logic              open_q, sup_q, err_q, sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_act;

  assign wr_act = sel_i & ~we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      sup_q  <= 1'b0;
      err_q  <= 1'b0;
      sel_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      sel_q <= sel_i;
      if (!open_q && wr_act) begin
        open_q <= 1'b1;
        addr_q <= addr_i;
        err_q  <= 1'b0;
        if (!sel_q) sup_q <= 1'b1;  // select arrived with or after write strobe
      end else if (open_q && !wr_act) begin
        open_q <= 1'b0;
      end
      if (open_q && wr_act && (addr_i != addr_q)) err_q <= 1'b1;
      if (!sel_i) sup_q <= 1'b0;
    end
  end

  assign open_o     = open_q;
  assign commit_o   = open_q & ~wr_act & ~block_i;
  assign wr_addr_o  = addr_q;
  assign suppress_o = sup_q;
  assign err_o      = err_q;
endmodule

// File: rtl/sbc_bank.sv
module sbc_bank #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/sram_bank_ctrl.sv
module sram_bank_ctrl
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              wp_i,
  input  logic              pfail_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic [1:0]        bank_ce_o,
  output logic              wr_open_o,
  output logic              addr_err_o
);
  localparam int BANK_AW = ADDR_W - 1;
  localparam int N_BANKS = 2;

  logic              blocked, sel, commit, suppress, open;
  logic [ADDR_W-1:0] wr_addr;
  sbc_mode_e         mode;
  logic [DATA_W-1:0] rdata [N_BANKS];

  assign blocked = wp_i | pfail_i;

  sbc_decode u_dec (
    .ce_ni   (ce_ni),
    .oe_ni   (oe_ni),
    .we_ni   (we_ni),
    .block_i (blocked),
    .mode_o  (mode),
    .sel_o   (sel)
  );

  sbc_wr_track #(.ADDR_W(ADDR_W)) u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .we_ni      (we_ni),
    .block_i    (blocked),
    .addr_i     (addr_i),
    .open_o     (open),
    .commit_o   (commit),
    .wr_addr_o  (wr_addr),
    .suppress_o (suppress),
    .err_o      (addr_err_o)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    assign bank_ce_o[b] = sel & (addr_i[ADDR_W-1] == b[0]);
    sbc_bank #(.ADDR_W(BANK_AW), .DATA_W(DATA_W)) u_bank (
      .clk_i   (clk_i),
      .we_i    (commit & (wr_addr[ADDR_W-1] == b[0])),
      .waddr_i (wr_addr[BANK_AW-1:0]),
      .wdata_i (dq_i),
      .raddr_i (addr_i[BANK_AW-1:0]),
      .rdata_o (rdata[b])
    );
  end

  assign dq_o      = rdata[addr_i[ADDR_W-1]];
  assign dq_oe_o   = (mode == MODE_READ) & ~suppress;
  assign wr_open_o = open;
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              we_ni,
  input logic              wp_i,
  input logic              pfail_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              dq_oe_o,
  input logic [1:0]        bank_ce_o,
  input logic              wr_open_o,
  input logic              addr_err_o
);
  a_r1_desel_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> (bank_ce_o == 2'b00) && !dq_oe_o);

  a_r4_window_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !we_ni && !wp_i && !pfail_i) |=> wr_open_o);

  a_r7_we_drops_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |-> !dq_oe_o);

  a_r10_one_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_ce_o));

  a_r10_bank_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_ce_o != 2'b00) |-> bank_ce_o[addr_i[ADDR_W-1]]);

  a_r11_block_deselects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_i || pfail_i) |-> (bank_ce_o == 2'b00) && !dq_oe_o);

  a_r11_no_open_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_i || pfail_i) |=> !$rose(wr_open_o));

  a_r12_err_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_err_o) |-> $past(wr_open_o));
endmodule

bind sram_bank_ctrl sbc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_ni      (ce_ni),
  .we_ni      (we_ni),
  .wp_i       (wp_i),
  .pfail_i    (pfail_i),
  .addr_i     (addr_i),
  .dq_oe_o    (dq_oe_o),
  .bank_ce_o  (bank_ce_o),
  .wr_open_o  (wr_open_o),
  .addr_err_o (addr_err_o)
);

// File: tb/sim_sram_bank_ctrl.sv
module sim_sram_bank_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wp = 1'b0, pf = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dq;
  logic          dq_oe, wr_open, addr_err;
  logic [1:0]    bank_ce;

  int vectors = 0;
  int errors  = 0;
  logic          rd_req = 1'b0;
  logic [DW-1:0] model [1<<AW];
  logic [DW-1:0] exp_q [$];
  logic [AW-1:0] addr_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_bank_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .wp_i(wp), .pfail_i(pf), .addr_i(addr), .dq_i(din), .dq_o(dq),
    .dq_oe_o(dq_oe), .bank_ce_o(bank_ce), .wr_open_o(wr_open),
    .addr_err_o(addr_err)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each read strobe
  always @(negedge clk) begin
    if (rd_req && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      logic [AW-1:0] a;
      e = exp_q.pop_front();
      a = addr_q.pop_front();
      chk(dq_oe === 1'b1, "R3 oe", dq_oe, 1);
      chk(dq === e, "R3 data", dq, e);
      chk(bank_ce === (2'b01 << a[AW-1]), "R10 bank", bank_ce, 2'b01 << a[AW-1]);
    end
  end

  task automatic rd(input logic [AW-1:0] a);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    exp_q.push_back(model[a]);
    addr_q.push_back(a);
    rd_req = 1'b1;
    tick();
    rd_req = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
    tick();
  endtask

  task automatic wr_we(input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; addr = a;
    tick();
    we_n = 1'b0; din = d;
    tick();
    chk(wr_open === 1'b1, "R5 open", wr_open, 1);
    we_n = 1'b1;
    tick();
    ce_n = 1'b1;
    tick();
    model[a] = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(wr_open === 1'b0 && addr_err === 1'b0 && dq_oe === 1'b0, "R13 reset",
        {wr_open, addr_err, dq_oe}, 0);
    rst_n = 1'b1;
    tick();

    // R1: deselect with oe active
    oe_n = 1'b0;
    @(negedge clk);
    chk(dq_oe === 1'b0 && bank_ce === 2'b00, "R1 deselect", {bank_ce, dq_oe}, 0);
    oe_n = 1'b1;
    tick();

    // R3 R5 R10 basic writes in both banks
    wr_we(8'h05, 8'hA5);
    wr_we(8'h21, 8'h99);
    wr_we(8'h90, 8'h5A);
    rd(8'h05);
    rd(8'h90);
    rd(8'h21);

    // R2 output disable
    ce_n = 1'b0; oe_n = 1'b1; addr = 8'h05;
    @(negedge clk);
    chk(dq_oe === 1'b0, "R2 output disable", dq_oe, 0);
    tick();
    ce_n = 1'b1;
    tick();

    // R4 R8: select falls after write strobe, oe low throughout
    ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b0; addr = 8'h85; din = 8'h3C;
    tick();
    ce_n = 1'b0;
    @(negedge clk);
    chk(dq_oe === 1'b0, "R4 oe ignored", dq_oe, 0);
    tick();
    chk(wr_open === 1'b1, "R4 window open", wr_open, 1);
    we_n = 1'b1;
    @(negedge clk);
    chk(dq_oe === 1'b0, "R8 held hiz", dq_oe, 0);
    tick();
    @(negedge clk);
    chk(dq_oe === 1'b0 && wr_open === 1'b0, "R8 still hiz", {wr_open, dq_oe}, 0);
    ce_n = 1'b1; oe_n = 1'b1;
    tick();
    model[8'h85] = 8'h3C;
    rd(8'h85);

    // R7 R9: write strobe during active read
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 8'h10;
    @(negedge clk);
    chk(dq_oe === 1'b1, "R9 read before", dq_oe, 1);
    tick();
    we_n = 1'b0; din = 8'h77;
    @(negedge clk);
    chk(dq_oe === 1'b0, "R7 we drops oe", dq_oe, 0);
    tick();
    we_n = 1'b1;
    @(negedge clk);
    chk(dq_oe === 1'b1, "R9 oe returns", dq_oe, 1);
    tick();
    @(negedge clk);
    chk(dq === 8'h77, "R9 new data", dq, 8'h77);
    ce_n = 1'b1; oe_n = 1'b1;
    tick();
    model[8'h10] = 8'h77;

    // R5: data taken at close, not at open
    ce_n = 1'b0; addr = 8'h40;
    tick();
    we_n = 1'b0; din = 8'h01;
    tick();
    din = 8'h02;
    tick();
    din = 8'hE7; we_n = 1'b1;
    tick();
    ce_n = 1'b1;
    tick();
    model[8'h40] = 8'hE7;
    rd(8'h40);

    // R6 R12: address moves inside window, select-ended close
    ce_n = 1'b0; addr = 8'h20;
    tick();
    we_n = 1'b0; din = 8'h11;
    tick();
    addr = 8'h21;
    tick();
    @(negedge clk);
    chk(addr_err === 1'b1, "R12 err set", addr_err, 1);
    ce_n = 1'b1;
    tick();
    we_n = 1'b1;
    tick();
    @(negedge clk);
    chk(addr_err === 1'b1, "R12 err held", addr_err, 1);
    model[8'h20] = 8'h11;
    rd(8'h20);
    rd(8'h21);
    wr_we(8'h22, 8'h33);
    @(negedge clk);
    chk(addr_err === 1'b0, "R12 err cleared", addr_err, 0);
    tick();

    // R11: write protect blocks open and commit
    wp = 1'b1; ce_n = 1'b0; we_n = 1'b0; addr = 8'h05; din = 8'hFF;
    @(negedge clk);
    chk(bank_ce === 2'b00, "R11 wp bank", bank_ce, 0);
    tick();
    chk(wr_open === 1'b0, "R11 wp no open", wr_open, 0);
    we_n = 1'b1;
    tick();
    ce_n = 1'b1; wp = 1'b0;
    tick();
    rd(8'h05);

    // R11: power fail blocks read and aborts open window
    pf = 1'b1; ce_n = 1'b0; oe_n = 1'b0; addr = 8'h05;
    @(negedge clk);
    chk(dq_oe === 1'b0, "R11 pfail hiz", dq_oe, 0);
    tick();
    pf = 1'b0; oe_n = 1'b1; we_n = 1'b0; din = 8'h42;
    tick();
    pf = 1'b1;
    tick();
    chk(wr_open === 1'b0, "R11 abort", wr_open, 0);
    ce_n = 1'b1; we_n = 1'b1;
    tick();
    pf = 1'b0;
    tick();
    rd(8'h05);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule